// File: doc/BRIEF.md
# Two-Level Priority Output Arbiter with Group Port Selection

This block decides which source port of a packet switch is connected next to one of a group of output ports. Every source presents a request, a priority bit and the set of output ports it may leave by. The arbiter keeps only sources for which at least one port of their set is ready and not busy. Among those, a high-priority source always wins over a low-priority one. Within each class, a round-robin pointer kept for that class alone shares the grants out fairly.

The winner receives a one-hot grant and the index of the output it will use. That index is the lowest-numbered free port of its set. Grant and index stay fixed until the granted source strobes its end-of-packet line, whether the packet ended normally or with an error. The arbiter then goes idle for one cycle before it arbitrates again. Moving the data and keeping the routing table belong to other blocks.

Top module: `prio_port_arbiter`

## Requirements
- R1: `grant` is one-hot or all zero at every cycle. While reset is applied, and after it until a request is granted, `grant` is zero and `grant_port` is 0.
- R2: A source is eligible when its `src_req` bit is 1 and its group contains at least one output with `out_ready`=1 and `out_busy`=0. The group of source i is `src_group[i*N_OUT + j]`, with bit j standing for output j. When the arbiter is idle and some source is eligible, the grant appears at the next clock edge, and only to a source that requested.
- R3: An eligible source with `src_hi`=1 is always granted before any eligible source with `src_hi`=0. A high-priority source with no free port does not hold back an eligible low-priority source.
- R4: Each priority class has its own round-robin pointer, which starts at source 0 after reset. After source s of a class is granted, the next search in that class begins at s+1 and wraps around. A grant in one class leaves the other class's pointer unchanged.
- R5: `grant_port` carries the lowest-numbered output j that is in the granted source's group, has `out_ready[j]`=1 and has `out_busy[j]`=0.
- R6: A requesting source none of whose group outputs is free is not granted; it waits until a port of its group becomes free.
- R7: Once given, `grant` and `grant_port` do not change until the granted source's `src_eop` bit is 1. While they are held, changes on `src_req`, `src_hi`, `src_group`, `out_ready` and `out_busy`, and `src_eop` from other sources, have no effect.
- R8: When the granted source's `src_eop` bit is 1 at a clock edge, `grant` is zero after that edge. A new grant can appear at the following edge at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | N_SRC | Request for an output, one bit per source |
| src_hi | input | N_SRC | Priority of each source's request, 1 = high |
| src_group | input | N_SRC*N_OUT | Allowed output set per source, bit i*N_OUT+j = output j |
| src_eop | input | N_SRC | End-of-packet strobe per source (normal or error end) |
| out_ready | input | N_OUT | Output port ready to accept a packet |
| out_busy | input | N_OUT | Output port already carrying a packet |
| grant | output | N_SRC | One-hot grant, zero when idle |
| grant_port | output | $clog2(N_OUT) | Output index given to the granted source |

## Verification
A wrong class pointer gives no visible fault on the first grant. It shows as the wrong winner at the second or third grant of a class, and only when several sources of that class wait together, so the tests repeat grant and release cycles with several requesters. A lost lock or a wrong state shows within one cycle: the grant changes while no end strobe was given, or it fails to drop after the strobe. A wrong port choice shows on `grant_port` in the same cycle as the grant. The tests therefore mark low-numbered ports busy or not ready, so that any choice other than the lowest free port shows up.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;

  localparam int unsigned CLASS_LO = 0;
  localparam int unsigned CLASS_HI = 1;
  localparam int unsigned N_CLASS  = 2;

endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/arb_rr_pick.sv
// Finds the first set request at or after the pointer, wrapping around.
module arb_rr_pick #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    // Walk downward so that the nearest position to the pointer is taken last.
    for (int k = N - 1; k >= 0; k--) begin
      int pos;
      pos = int'(ptr) + k;
      if (pos >= int'(N)) pos = pos - int'(N);
      if (req[pos]) begin
        found = 1'b1;
        idx   = IW'(pos);
      end
    end
  end

endmodule

// File: rtl/arb_port_pick.sv
// Lowest-numbered available output of a mask.
module arb_port_pick #(
  parameter int unsigned M  = 4,
  localparam int unsigned OW = (M > 1) ? $clog2(M) : 1
) (
  input  logic [M-1:0]  avail,
  output logic          found,
  output logic [OW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int j = M - 1; j >= 0; j--) begin
      if (avail[j]) begin
        found = 1'b1;
        idx   = OW'(j);
      end
    end
  end

endmodule

// File: rtl/prio_port_arbiter.sv
module prio_port_arbiter
  import prio_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned N_OUT = 4,
  localparam int unsigned SW   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned OW   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       src_req,
  input  logic [N_SRC-1:0]       src_hi,
  input  logic [N_SRC*N_OUT-1:0] src_group,
  input  logic [N_SRC-1:0]       src_eop,
  input  logic [N_OUT-1:0]       out_ready,
  input  logic [N_OUT-1:0]       out_busy,
  output logic [N_SRC-1:0]       grant,
  output logic [OW-1:0]          grant_port
);

  logic rst_int_n;

  arb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // Per-source eligibility and port choice.
  logic [N_OUT-1:0] out_free;
  logic [N_SRC-1:0] src_has_port;
  logic [OW-1:0]    src_port [N_SRC];
  logic [N_SRC-1:0] src_elig;

  assign out_free = out_ready & ~out_busy;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    arb_port_pick #(.M(N_OUT)) u_pp (
      .avail (src_group[i*N_OUT +: N_OUT] & out_free),
      .found (src_has_port[i]),
      .idx   (src_port[i])
    );
  end

  assign src_elig = src_req & src_has_port;

  // One round-robin picker per priority class.
  logic [N_SRC-1:0] cls_req   [N_CLASS];
  logic [SW-1:0]    ptr_q     [N_CLASS];
  logic [SW-1:0]    ptr_d     [N_CLASS];
  logic             cls_found [N_CLASS];
  logic [SW-1:0]    cls_idx   [N_CLASS];

  assign cls_req[CLASS_LO] = src_elig & ~src_hi;
  assign cls_req[CLASS_HI] = src_elig &  src_hi;

  for (genvar c = 0; c < N_CLASS; c++) begin : g_cls
    arb_rr_pick #(.N(N_SRC)) u_rr (
      .req   (cls_req[c]),
      .ptr   (ptr_q[c]),
      .found (cls_found[c]),
      .idx   (cls_idx[c])
    );
  end

  logic          any_found;
  logic          win_hi;
  logic [SW-1:0] win_idx;
  logic [SW-1:0] win_next;

  assign win_hi    = cls_found[CLASS_HI];
  assign any_found = cls_found[CLASS_HI] | cls_found[CLASS_LO];
  assign win_idx   = win_hi ? cls_idx[CLASS_HI] : cls_idx[CLASS_LO];
  assign win_next  = (int'(win_idx) == int'(N_SRC) - 1) ? '0 : win_idx + 1'b1;

  // State registers.
  arb_state_e       state_q, state_d;
  logic [N_SRC-1:0] grant_q, grant_d;
  logic [OW-1:0]    port_q, port_d;
  logic             release_now;
  logic             start_now;
  logic             upd_en;

  assign release_now = (state_q == ARB_HELD) && ((src_eop & grant_q) != '0);
  assign start_now   = (state_q == ARB_IDLE) && any_found;
  assign upd_en      = release_now | start_now;

  always_comb begin
    state_d = state_q;
    grant_d = grant_q;
    port_d  = port_q;
    for (int c = 0; c < int'(N_CLASS); c++) ptr_d[c] = ptr_q[c];
    if (start_now) begin
      state_d = ARB_HELD;
      grant_d = '0;
      grant_d[win_idx] = 1'b1;
      port_d  = src_port[win_idx];
      if (win_hi) ptr_d[CLASS_HI] = win_next;
      else        ptr_d[CLASS_LO] = win_next;
    end else if (release_now) begin
      state_d = ARB_IDLE;
      grant_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
      port_q  <= '0;
      for (int c = 0; c < int'(N_CLASS); c++) ptr_q[c] <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      grant_q <= grant_d;
      port_q  <= port_d;
      for (int c = 0; c < int'(N_CLASS); c++) ptr_q[c] <= ptr_d[c];
    end
  end

  assign grant      = grant_q;
  assign grant_port = port_q;

endmodule

// File: rtl/prio_port_arbiter_chk.sv
module prio_port_arbiter_chk #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned N_OUT = 4,
  localparam int unsigned OW   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_SRC-1:0]       src_req,
  input logic [N_SRC-1:0]       src_hi,
  input logic [N_SRC*N_OUT-1:0] src_group,
  input logic [N_SRC-1:0]       src_eop,
  input logic [N_OUT-1:0]       out_ready,
  input logic [N_OUT-1:0]       out_busy,
  input logic [N_SRC-1:0]       grant,
  input logic [OW-1:0]          grant_port
);

  logic [N_OUT-1:0] free_now;
  logic             hi_elig_now;
  logic             any_elig_now;

  assign free_now = out_ready & ~out_busy;

  always_comb begin
    hi_elig_now  = 1'b0;
    any_elig_now = 1'b0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (src_req[i] && ((src_group[i*N_OUT +: N_OUT] & free_now) != '0)) begin
        any_elig_now = 1'b1;
        if (src_hi[i]) hi_elig_now = 1'b1;
      end
    end
  end

  logic                   idle_q;
  logic [N_SRC-1:0]       req_q;
  logic [N_SRC-1:0]       hi_q;
  logic                   hi_elig_q;
  logic [N_OUT-1:0]       free_q;
  logic [N_SRC*N_OUT-1:0] grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q    <= 1'b1;
      req_q     <= '0;
      hi_q      <= '0;
      hi_elig_q <= 1'b0;
      free_q    <= '0;
      grp_q     <= '0;
    end else begin
      idle_q    <= (grant == '0);
      req_q     <= src_req;
      hi_q      <= src_hi;
      hi_elig_q <= hi_elig_now;
      free_q    <= free_now;
      grp_q     <= src_group;
    end
  end

  logic new_grant;
  logic grp_bit;

  assign new_grant = idle_q && (grant != '0);

  always_comb begin
    grp_bit = 1'b0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (grant[i]) grp_bit = grp_q[i*N_OUT + int'(grant_port)];
    end
  end

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_grant_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    new_grant |-> ((grant & req_q) != '0));

  p_hi_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (new_grant && ((grant & hi_q) == '0)) |-> !hi_elig_q);

  p_port_free_in_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    new_grant |-> (free_q[grant_port] && grp_bit));

  p_wait_no_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant == '0) && !any_elig_now) |=> (grant == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && ((grant & src_eop) == '0))
      |=> ((grant == $past(grant)) && (grant_port == $past(grant_port))));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & src_eop) != '0) |=> (grant == '0));

endmodule

bind prio_port_arbiter prio_port_arbiter_chk #(
  .N_SRC (N_SRC),
  .N_OUT (N_OUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_req    (src_req),
  .src_hi     (src_hi),
  .src_group  (src_group),
  .src_eop    (src_eop),
  .out_ready  (out_ready),
  .out_busy   (out_busy),
  .grant      (grant),
  .grant_port (grant_port)
);

// File: tb/prio_port_arbiter_test.sv
module prio_port_arbiter_test;

  localparam int NS = 4;
  localparam int NO = 4;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] src_req;
  logic [NS-1:0] src_hi;
  logic [NS*NO-1:0] src_group;
  logic [NS-1:0] src_eop;
  logic [NO-1:0] out_ready;
  logic [NO-1:0] out_busy;
  logic [NS-1:0] grant;
  logic [1:0]    grant_port;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  prio_port_arbiter #(.N_SRC(NS), .N_OUT(NO)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .src_hi     (src_hi),
    .src_group  (src_group),
    .src_eop    (src_eop),
    .out_ready  (out_ready),
    .out_busy   (out_busy),
    .grant      (grant),
    .grant_port (grant_port)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_eq(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_grant(string tag, int g, int p);
    check_eq({tag, " grant"}, int'(grant), g);
    if (g != 0) check_eq({tag, " port"}, int'(grant_port), p);
  endtask

  // Strobe end of packet for the granted source; R8: grant drops after that edge.
  task automatic release_grant(string tag);
    src_eop = grant;
    step();
    check_eq({tag, " R8 release"}, int'(grant), 0);
    src_eop = '0;
    step();
  endtask

  task automatic set_grp(int i, logic [NO-1:0] m);
    src_group[i*NO +: NO] = m;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    src_req   = '0;
    src_hi    = '0;
    src_group = '0;
    src_eop   = '0;
    out_ready = '1;
    out_busy  = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    src_req = '1; src_hi = '0; src_group = '1; src_eop = '0;
    out_ready = '1; out_busy = '0;
    repeat (3) step();
    check_eq("R1 grant in reset", int'(grant), 0);
    check_eq("R1 port in reset", int'(grant_port), 0);
    do_reset();
    check_eq("R1 grant idle after reset", int'(grant), 0);
  endtask

  task automatic t_single();
    do_reset();
    set_grp(2, 4'b0110);
    src_req = 4'b0100;
    step();
    expect_grant("R2 single request", 4'b0100, 1);
    src_req = '0;
    release_grant("R8 single");
    check_eq("R8 stays idle without request", int'(grant), 0);
  endtask

  task automatic t_priority();
    do_reset();
    set_grp(0, 4'b0001); set_grp(3, 4'b0001);
    src_req = 4'b1001; src_hi = 4'b1000;
    step();
    expect_grant("R3 high wins", 4'b1000, 0);
    src_req = 4'b0001;
    release_grant("R3");
    expect_grant("R3 low after high", 4'b0001, 0);
  endtask

  task automatic t_rr_lo();
    do_reset();
    for (int i = 0; i < 3; i++) set_grp(i, 4'b0001);
    src_req = 4'b0111;
    step();
    expect_grant("R4 rr first", 4'b0001, 0);
    release_grant("R4");
    expect_grant("R4 rr second", 4'b0010, 0);
    release_grant("R4");
    expect_grant("R4 rr third", 4'b0100, 0);
    release_grant("R4");
    expect_grant("R4 rr wrap", 4'b0001, 0);
  endtask

  task automatic t_class_ptrs();
    do_reset();
    for (int i = 0; i < 4; i++) set_grp(i, 4'b0001);
    src_req = 4'b1111; src_hi = 4'b1010;
    step();
    expect_grant("R4 hi first", 4'b0010, 0);
    release_grant("R4");
    expect_grant("R4 hi second", 4'b1000, 0);
    release_grant("R4");
    expect_grant("R4 hi wrap", 4'b0010, 0);
    src_eop = grant; src_req = 4'b0101;
    step();
    src_eop = '0;
    step();
    expect_grant("R4 lo pointer untouched", 4'b0001, 0);
  endtask

  task automatic t_group();
    do_reset();
    set_grp(0, 4'b1111);
    out_busy = 4'b0011;
    src_req = 4'b0001;
    step();
    expect_grant("R5 skip busy ports", 4'b0001, 2);
    src_eop = grant;
    step();
    src_eop = '0; out_ready = 4'b1100; out_busy = 4'b0100;
    step();
    expect_grant("R5 skip unready and busy", 4'b0001, 3);
  endtask

  task automatic t_wait();
    do_reset();
    set_grp(1, 4'b0110);
    out_busy = 4'b0110;
    src_req = 4'b0010;
    step();
    check_eq("R6 no free port waits", int'(grant), 0);
    step();
    check_eq("R6 still waiting", int'(grant), 0);
    out_busy = 4'b0010;
    step();
    expect_grant("R6 granted once free", 4'b0010, 2);
  endtask

  task automatic t_hi_blocked();
    do_reset();
    set_grp(1, 4'b0001); set_grp(2, 4'b0010);
    out_busy = 4'b0001;
    src_req = 4'b0110; src_hi = 4'b0010;
    step();
    expect_grant("R3 blocked high does not stall low", 4'b0100, 1);
  endtask

  task automatic t_hold();
    do_reset();
    set_grp(0, 4'b0001); set_grp(3, 4'b1111);
    src_req = 4'b0001;
    step();
    expect_grant("R7 initial", 4'b0001, 0);
    src_req = 4'b1000; src_hi = 4'b1000; out_busy = 4'b0001; src_eop = 4'b1000;
    step();
    expect_grant("R7 held under changes", 4'b0001, 0);
    set_grp(0, 4'b0110); out_ready = 4'b1110;
    step();
    expect_grant("R7 held, other eop ignored", 4'b0001, 0);
    out_ready = 4'b1111;
    src_eop = 4'b0001;
    step();
    check_eq("R8 release on own eop", int'(grant), 0);
    src_eop = '0;
    step();
    expect_grant("R8 next grant one cycle later", 4'b1000, 1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_priority();
    t_rr_lo();
    t_class_ptrs();
    t_group();
    t_wait();
    t_hi_blocked();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule